// File: doc/BRIEF.md
# Base Address Window Decoder

This block decides whether a bus transaction belongs to one target. It holds up to six address windows. Each window is fixed at build time as either a memory window or an I/O window, and each has a fixed power-of-two size. Configuration software first finds a window's size. It writes all ones to the window's register and reads back a value whose low bits come back as zero. It then writes the base address it has chosen. Base bits that fall below the window size cannot be written.

When a transaction starts, the decoder captures the address and sorts the command nibble into one of three classes: memory, I/O, or neither. Memory commands are compared only against memory windows, and I/O commands only against I/O windows. Configuration commands never reach the window compare. During a burst the decoder advances its own copy of the address by one 32-bit word on every data phase, so the hit flag follows the burst across a window edge. The outputs are a hit flag and the index of the matching window. When windows overlap, the lowest index wins.

Top module: `bar_window_decoder`

## Requirements
- R1: The windows sit at configuration dword indices 4 to 4+NUM_WIN-1, that is byte offsets 0x10 upward, one window per dword. Any other index in the 6-bit dword space reads as zero, and a write to it changes nothing.
- R2: A window register reads back as its base with bit 0 set for an I/O window and clear for a memory window. After an all-ones write, the default windows 0..5 read 0xFFFFF000, 0xFFFFFF01, 0xFFFFFFF0, 0xFFFFFFFD, 0xFFFF0000 and 0xFFFFFFF1.
- R3: Written bits below a window's size are dropped. A memory window is never smaller than 16 bytes and an I/O window never smaller than 4 bytes; a smaller build-time size is raised to that minimum.
- R4: Commands 0110, 0111, 1100, 1110 and 1111 are memory class and can hit only memory windows. Commands 0010 and 0011 are I/O class and can hit only I/O windows. A window hits when the tracked address, with the bits below the window size cleared, equals its base.
- R5: Commands 1010 and 1011, and every other code not listed in R4, never produce a hit.
- R6: The address and command are captured on a clock edge where txn_start is high. Hit and hit_idx reflect them from the next cycle. On each later edge where both init_rdy and tgt_rdy are high, the tracked address increases by 4.
- R7: txn_start takes priority over txn_end and over a data-phase advance in the same cycle. txn_end alone ends the transaction, and hit is low from the next cycle.
- R8: Reset clears every base and ends any transaction. A window whose base is zero never hits.
- R9: When several windows match, hit_idx gives the lowest matching index.
- R10: hit_idx is zero whenever hit is low.
- R11: A base write in the middle of a burst applies to the decode in the next cycle, together with any address advance made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_idx | input | 6 | Configuration dword index (256-byte space) |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Configuration read data for cfg_dw_idx |
| txn_start | input | 1 | Address phase: capture bus_addr and bus_cmd |
| txn_end | input | 1 | Transaction finished |
| bus_addr | input | ADDR_W | Address-phase address |
| bus_cmd | input | 4 | Address-phase command nibble |
| init_rdy | input | 1 | Initiator ready, active high |
| tgt_rdy | input | 1 | Target ready, active high |
| hit | output | 1 | Tracked address falls inside a window of matching type |
| hit_idx | output | 3 | Index of the winning window |

## Verification
Two things can happen on the same edge: a configuration base write and a burst address advance. The bench starts an I/O burst on a 4-byte window. In one cycle it both moves that window's base up one word and raises both ready strobes. The hit must hold in the next cycle, because the new base and the advanced address line up. The following advance must then drop the hit. The bench also raises the ready strobes, or txn_end, in the same cycle as txn_start. It judges the result by whether the start address, and not a neighbouring one, is decoded.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    localparam int MAX_WIN     = 6;
    localparam int IDX_W       = 3;
    localparam int CFG_IDX_W   = 6;
    localparam int BAR_DW0     = 4;
    localparam int BURST_STEP  = 4;
    localparam int MEM_MIN_LG2 = 4;
    localparam int IO_MIN_LG2  = 2;

    localparam logic [3:0] CMD_IO_RD    = 4'b0010;
    localparam logic [3:0] CMD_IO_WR    = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD   = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR   = 4'b0111;
    localparam logic [3:0] CMD_MEM_RDM  = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL  = 4'b1110;
    localparam logic [3:0] CMD_MEM_WRI  = 4'b1111;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_MEM  = 2'd1,
        CLS_IO   = 2'd2
    } cmd_cls_e;

    typedef struct packed {
        logic     active;
        cmd_cls_e cls;
    } txn_state_t;

    function automatic cmd_cls_e cmd_class(input logic [3:0] cmd);
        case (cmd)
            CMD_IO_RD, CMD_IO_WR:                   return CLS_IO;
            CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
            CMD_MEM_RDL, CMD_MEM_WRI:               return CLS_MEM;
            default:                                return CLS_NONE;
        endcase
    endfunction

    function automatic int eff_lg2(input int raw, input bit is_io);
        int lo;
        lo = is_io ? IO_MIN_LG2 : MEM_MIN_LG2;
        return (raw < lo) ? lo : raw;
    endfunction

    function automatic logic [63:0] win_mask64(input int lg2);
        return ~((64'd1 << lg2) - 64'd1);
    endfunction

endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
    import bar_dec_pkg::*;
#(
    parameter int                       NUM_WIN      = 6,
    parameter int                       ADDR_W       = 32,
    parameter logic [MAX_WIN-1:0]       WIN_IS_IO    = 6'b101010,
    parameter logic [8*MAX_WIN-1:0]     WIN_SIZE_LG2 = {8'd4, 8'd16, 8'd1, 8'd2, 8'd8, 8'd12}
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_wr,
    input  logic [CFG_IDX_W-1:0]              cfg_dw_idx,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic [ADDR_W-1:0]                 cfg_rdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]    bases
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] rd_val;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam int              LG2  = eff_lg2(int'(WIN_SIZE_LG2[8*i +: 8]), WIN_IS_IO[i]);
        localparam logic [63:0]     M64  = win_mask64(LG2);
        localparam logic [ADDR_W-1:0] MASK = M64[ADDR_W-1:0];
        localparam logic [CFG_IDX_W-1:0] MY_IDX = CFG_IDX_W'(BAR_DW0 + i);

        logic [ADDR_W-1:0] base_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
            end else if (cfg_wr && (cfg_dw_idx == MY_IDX)) begin
                base_q <= cfg_wdata & MASK;
            end
        end

        assign bases[i]  = base_q;
        assign rd_val[i] = base_q | ADDR_W'(WIN_IS_IO[i]);
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cfg_dw_idx == CFG_IDX_W'(BAR_DW0 + i)) begin
                cfg_rdata = rd_val[i];
            end
        end
    end

endmodule

// File: rtl/bar_addr_tracker.sv
module bar_addr_tracker
    import bar_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic              txn_end,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_cmd,
    input  logic              init_rdy,
    input  logic              tgt_rdy,
    output logic [ADDR_W-1:0] cur_addr,
    output txn_state_t        cur_state
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_STEP);

    logic [ADDR_W-1:0] addr_q;
    txn_state_t        st_q;
    logic              data_phase;

    assign data_phase = st_q.active && init_rdy && tgt_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            st_q      <= '{active: 1'b0, cls: CLS_NONE};
        end else if (txn_start) begin
            addr_q    <= bus_addr;
            st_q      <= '{active: 1'b1, cls: cmd_class(bus_cmd)};
        end else if (txn_end) begin
            st_q      <= '{active: 1'b0, cls: CLS_NONE};
        end else if (data_phase) begin
            addr_q    <= addr_q + STEP;
        end
    end

    assign cur_addr  = addr_q;
    assign cur_state = st_q;

endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_dec_pkg::*;
#(
    parameter int                       NUM_WIN      = 6,
    parameter int                       ADDR_W       = 32,
    parameter logic [MAX_WIN-1:0]       WIN_IS_IO    = 6'b101010,
    parameter logic [8*MAX_WIN-1:0]     WIN_SIZE_LG2 = {8'd4, 8'd16, 8'd1, 8'd2, 8'd8, 8'd12}
) (
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] bases,
    input  logic [ADDR_W-1:0]              cur_addr,
    input  txn_state_t                     cur_state,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);

    logic [NUM_WIN-1:0] win_hit;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        localparam int                LG2  = eff_lg2(int'(WIN_SIZE_LG2[8*i +: 8]), WIN_IS_IO[i]);
        localparam logic [63:0]       M64  = win_mask64(LG2);
        localparam logic [ADDR_W-1:0] MASK = M64[ADDR_W-1:0];
        localparam cmd_cls_e          WANT = WIN_IS_IO[i] ? CLS_IO : CLS_MEM;

        logic type_ok;
        logic base_set;
        logic addr_eq;

        assign type_ok  = cur_state.active && (cur_state.cls == WANT);
        assign base_set = |bases[i];
        assign addr_eq  = ((cur_addr & MASK) == bases[i]);
        assign win_hit[i] = type_ok && base_set && addr_eq;
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int                       NUM_WIN      = 6,
    parameter int                       ADDR_W       = 32,
    parameter logic [MAX_WIN-1:0]       WIN_IS_IO    = 6'b101010,
    parameter logic [8*MAX_WIN-1:0]     WIN_SIZE_LG2 = {8'd4, 8'd16, 8'd1, 8'd2, 8'd8, 8'd12}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [CFG_IDX_W-1:0]  cfg_dw_idx,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic [ADDR_W-1:0]     cfg_rdata,
    input  logic                  txn_start,
    input  logic                  txn_end,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [3:0]            bus_cmd,
    input  logic                  init_rdy,
    input  logic                  tgt_rdy,
    output logic                  hit,
    output logic [IDX_W-1:0]      hit_idx
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] bases;
    logic [ADDR_W-1:0]              trk_addr;
    txn_state_t                     trk_state;

    bar_cfg_regs #(
        .NUM_WIN      (NUM_WIN),
        .ADDR_W       (ADDR_W),
        .WIN_IS_IO    (WIN_IS_IO),
        .WIN_SIZE_LG2 (WIN_SIZE_LG2)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_dw_idx (cfg_dw_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .bases      (bases)
    );

    bar_addr_tracker #(
        .ADDR_W (ADDR_W)
    ) u_trk (
        .clk       (clk),
        .rst       (rst),
        .txn_start (txn_start),
        .txn_end   (txn_end),
        .bus_addr  (bus_addr),
        .bus_cmd   (bus_cmd),
        .init_rdy  (init_rdy),
        .tgt_rdy   (tgt_rdy),
        .cur_addr  (trk_addr),
        .cur_state (trk_state)
    );

    bar_match #(
        .NUM_WIN      (NUM_WIN),
        .ADDR_W       (ADDR_W),
        .WIN_IS_IO    (WIN_IS_IO),
        .WIN_SIZE_LG2 (WIN_SIZE_LG2)
    ) u_match (
        .bases     (bases),
        .cur_addr  (trk_addr),
        .cur_state (trk_state),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk
    import bar_dec_pkg::*;
#(
    parameter int                 NUM_WIN   = 6,
    parameter int                 ADDR_W    = 32,
    parameter logic [MAX_WIN-1:0] WIN_IS_IO = 6'b101010
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CFG_IDX_W-1:0] cfg_dw_idx,
    input logic [ADDR_W-1:0]    cfg_rdata,
    input logic                 txn_start,
    input logic                 txn_end,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [3:0]           bus_cmd,
    input logic                 init_rdy,
    input logic                 tgt_rdy,
    input logic                 hit,
    input logic [IDX_W-1:0]     hit_idx,
    input logic [ADDR_W-1:0]    trk_addr
);

    logic     seen_active;
    cmd_cls_e seen_cls;
    logic [CFG_IDX_W-1:0] rd_off;
    logic                 rd_in_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_active <= 1'b0;
            seen_cls    <= CLS_NONE;
        end else if (txn_start) begin
            seen_active <= 1'b1;
            seen_cls    <= cmd_class(bus_cmd);
        end else if (txn_end) begin
            seen_active <= 1'b0;
        end
    end

    assign rd_off    = cfg_dw_idx - CFG_IDX_W'(BAR_DW0);
    assign rd_in_win = (cfg_dw_idx >= CFG_IDX_W'(BAR_DW0)) && (rd_off < CFG_IDX_W'(NUM_WIN));

    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == '0));                                               // R10

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(hit_idx) < NUM_WIN));                                      // R9

    AST_NO_BYPASS_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |-> (seen_active && seen_cls != CLS_NONE));                          // R5

    AST_START_LATCH: assert property (@(posedge clk) disable iff (rst)
        txn_start |=> (trk_addr == $past(bus_addr)));                            // R6

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (seen_active && !txn_start && !txn_end && init_rdy && tgt_rdy)
        |=> (trk_addr == $past(trk_addr) + ADDR_W'(BURST_STEP)));                // R6

    AST_END_DROPS_HIT: assert property (@(posedge clk) disable iff (rst)
        (txn_end && !txn_start) |=> !hit);                                       // R7

    AST_TYPE_BIT: assert property (@(posedge clk) disable iff (rst)
        rd_in_win |-> (cfg_rdata[0] == WIN_IS_IO[rd_off[2:0]]));                 // R2

endmodule

bind bar_window_decoder bar_window_decoder_chk #(
    .NUM_WIN   (NUM_WIN),
    .ADDR_W    (ADDR_W),
    .WIN_IS_IO (WIN_IS_IO)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_dw_idx (cfg_dw_idx),
    .cfg_rdata  (cfg_rdata),
    .txn_start  (txn_start),
    .txn_end    (txn_end),
    .bus_addr   (bus_addr),
    .bus_cmd    (bus_cmd),
    .init_rdy   (init_rdy),
    .tgt_rdy    (tgt_rdy),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .trk_addr   (trk_addr)
);

// File: tb/bar_window_decoder_tb.sv
`timescale 1ns/100ps
module bar_window_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        txn_start = 1'b0;
    logic        txn_end = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [3:0]  bus_cmd = '0;
    logic        init_rdy = 1'b0;
    logic        tgt_rdy = 1'b0;
    logic        hit;
    logic [2:0]  hit_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Effective window sizes (log2 bytes) and types, from R2/R3.
    int sz [6] = '{12, 8, 4, 2, 16, 4};
    bit io [6] = '{0, 1, 0, 1, 0, 1};

    typedef struct {
        bit          is_rd;
        bit          exp_hit;
        int          exp_idx;
        logic [31:0] exp_data;
        string       req;
    } item_t;

    item_t sb [$];

    always #2.5 clk = ~clk;

    bar_window_decoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_dw_idx (cfg_dw_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .txn_start  (txn_start),
        .txn_end    (txn_end),
        .bus_addr   (bus_addr),
        .bus_cmd    (bus_cmd),
        .init_rdy   (init_rdy),
        .tgt_rdy    (tgt_rdy),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    function automatic logic [31:0] msk(input int lg2);
        return ~((32'd1 << lg2) - 32'd1);
    endfunction

    // Monitor: pops expectations and compares against the ports.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.is_rd) begin
                if (cfg_rdata !== it.exp_data) begin
                    errors++;
                    $display("FAIL %s rdata actual=%08h expected=%08h", it.req, cfg_rdata, it.exp_data);
                end
            end else if (hit !== it.exp_hit || int'(hit_idx) != it.exp_idx) begin
                errors++;
                $display("FAIL %s actual hit=%0b idx=%0d expected hit=%0b idx=%0d",
                         it.req, hit, hit_idx, it.exp_hit, it.exp_idx);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_dec(input bit h, input int idx, input string req);
        item_t it;
        it.is_rd = 0; it.exp_hit = h; it.exp_idx = idx; it.exp_data = '0; it.req = req;
        sb.push_back(it);
        @(negedge clk);
        #0.1;
    endtask

    task automatic chk_rd(input int idx, input logic [31:0] exp, input string req);
        item_t it;
        cfg_dw_idx = 6'(idx);
        #0.1;
        it.is_rd = 1; it.exp_hit = 0; it.exp_idx = 0; it.exp_data = exp; it.req = req;
        sb.push_back(it);
        @(negedge clk);
        #0.1;
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] d);
        cfg_dw_idx = 6'(idx);
        cfg_wdata  = d;
        cfg_wr     = 1'b1;
        tick();
        cfg_wr     = 1'b0;
    endtask

    task automatic start(input logic [31:0] a, input logic [3:0] c);
        bus_addr  = a;
        bus_cmd   = c;
        txn_start = 1'b1;
        tick();
        txn_start = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;

        // Reset state
        chk_dec(0, 0, "R8 R10 reset");
        for (int w = 0; w < 6; w++) chk_rd(4 + w, 32'(io[w]), "R8 reset base zero");

        // Size probe
        for (int w = 0; w < 6; w++) cfg_write(4 + w, 32'hFFFF_FFFF);
        for (int w = 0; w < 6; w++) chk_rd(4 + w, msk(sz[w]) | 32'(io[w]), "R2 R3 probe");

        // Non-window indices
        cfg_write(3, 32'hFFFF_FFFF);
        chk_rd(3, 32'h0, "R1 idx3");
        chk_rd(10, 32'h0, "R1 idx10");
        chk_rd(4, 32'hFFFF_F000, "R1 win0 untouched");

        // Program bases
        cfg_write(4, 32'h4000_0ABC);
        chk_rd(4, 32'h4000_0000, "R3 low bits dropped");
        cfg_write(5, 32'h0000_1000);
        cfg_write(6, 32'h5000_0010);
        cfg_write(7, 32'h0000_2006);
        chk_rd(7, 32'h0000_2005, "R3 io min size");
        cfg_write(8, 32'h4000_0000);
        cfg_write(9, 32'h0);

        // Decode
        start(32'h4000_0100, 4'b0110); chk_dec(1, 0, "R9 overlap lowest");
        start(32'h4000_2000, 4'b1100); chk_dec(1, 4, "R4 mem rdm");
        start(32'h4000_2000, 4'b1110); chk_dec(1, 4, "R4 mem rdl");
        start(32'h4000_2000, 4'b1111); chk_dec(1, 4, "R4 mem wri");
        start(32'h0000_1010, 4'b0111); chk_dec(0, 0, "R4 mem cmd io window");
        start(32'h0000_1010, 4'b0010); chk_dec(1, 1, "R4 io read");
        start(32'h4000_0100, 4'b0011); chk_dec(0, 0, "R4 io cmd mem window");
        start(32'h4000_0100, 4'b1010); chk_dec(0, 0, "R5 R10 cfg read");
        start(32'h4000_0100, 4'b1011); chk_dec(0, 0, "R5 cfg write");
        start(32'h4000_0100, 4'b0100); chk_dec(0, 0, "R5 reserved");
        start(32'h0000_0004, 4'b0010); chk_dec(0, 0, "R8 zero base");

        // Burst tracking
        start(32'h5000_0014, 4'b0111); chk_dec(1, 2, "R6 burst start");
        init_rdy = 1'b1; tgt_rdy = 1'b0;
        tick(); chk_dec(1, 2, "R6 no advance one strobe");
        tgt_rdy = 1'b1;
        tick(); chk_dec(1, 2, "R6 addr 0x18");
        tick(); chk_dec(1, 2, "R6 addr 0x1C");
        tick(); chk_dec(0, 0, "R6 crossed edge");
        init_rdy = 1'b0; tgt_rdy = 1'b0;

        // End and start priority
        start(32'h5000_0014, 4'b0111); chk_dec(1, 2, "R7 before end");
        txn_end = 1'b1; tick(); txn_end = 1'b0;
        chk_dec(0, 0, "R7 end");
        init_rdy = 1'b1; tgt_rdy = 1'b1;
        start(32'h5000_001C, 4'b0110); chk_dec(1, 2, "R7 start beats advance");
        init_rdy = 1'b0; tgt_rdy = 1'b0;
        tick(); chk_dec(1, 2, "R7 held");
        txn_end = 1'b1;
        start(32'h4000_0100, 4'b0110);
        txn_end = 1'b0;
        chk_dec(1, 0, "R7 start beats end");

        // Base write in the same cycle as an advance
        start(32'h0000_2004, 4'b0011); chk_dec(1, 3, "R11 before");
        cfg_dw_idx = 6'd7; cfg_wdata = 32'h0000_2008; cfg_wr = 1'b1;
        init_rdy = 1'b1; tgt_rdy = 1'b1;
        tick();
        cfg_wr = 1'b0; init_rdy = 1'b0; tgt_rdy = 1'b0;
        chk_dec(1, 3, "R11 new base and advance");
        init_rdy = 1'b1; tgt_rdy = 1'b1;
        tick();
        init_rdy = 1'b0; tgt_rdy = 1'b0;
        chk_dec(0, 0, "R11 past new window");
        start(32'h0000_2004, 4'b0011); chk_dec(0, 0, "R11 old base gone");

        // Reset mid-transaction
        start(32'h4000_0100, 4'b0110); chk_dec(1, 0, "R8 pre reset");
        rst = 1'b1; tick(); rst = 1'b0;
        chk_dec(0, 0, "R8 reset ends txn");
        chk_rd(4, 32'h0, "R8 reset clears base");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule